// File: doc/BRIEF.md
# DMA Channel Interrupt Request Bank

This block keeps one interrupt-pending flag and one DONE flag for every channel of a 64-channel DMA engine. When the transfer engine finishes a transfer it sends a one-cycle completion pulse with the channel number and that descriptor's interrupt-enable bit. The DONE flag for the channel is always set. The pending flag is set only when the interrupt enable is on. Every pending flag leaves the block as its own interrupt request line, with no gating.

Software sees the pending bitmap through two 32-bit words on a simple register port. It has two ways to retire requests. The first is a write-one-to-clear on either bitmap word. The second is an encoded command byte that clears one channel, clears every channel, or does nothing. This saves a read-modify-write from an interrupt handler. A second command register takes the same byte format and acts on the DONE flags. A hardware completion that arrives in the same cycle as a software clear of the same flag always wins, so no completion event is lost.

Top module: `dma_irq_bank`

## Requirements
- R1: While `rst` is high at a clock edge, every `irq_o` bit, every `done_o` bit and `bus_rdata_o` become 0.
- R2: A cycle with `cmpl_vld_i`=1 and `cmpl_irq_en_i`=1 sets `irq_o[cmpl_ch_i]` after that edge. With `cmpl_irq_en_i`=0 the pending bit is not set. No pending bit rises without such a completion.
- R3: Each completion sets `done_o[cmpl_ch_i]` after the edge, whatever the interrupt enable.
- R4: Address 0 holds channels 31..0 and address 1 holds channels 63..32, with data bit k standing for channel k (low word) or channel 32+k (high word). Bit 31 of the high word is channel 63 and bit 0 of the high word is channel 32. A read strobe at an edge places the pending state from before that edge on `bus_rdata_o` for the following cycle. `bus_rdata_o` is 0 in any cycle that follows no read.
- R5: A write to address 0 or 1 clears each channel whose data bit is 1 and leaves each channel whose data bit is 0 unchanged. Such writes never change `done_o`.
- R6: Address 2 takes a command byte in `bus_wdata_i[7:0]`. If bit 7 is 1, the write changes nothing, whatever bits 6..0 hold.
- R7: With bit 7 at 0, a value of 0..63 in bits 6..0 clears that one channel's pending bit and no other.
- R8: With bit 7 at 0, a value of 64..127 in bits 6..0 clears every pending bit.
- R9: Address 3 takes the same byte format, including the no-op, single-channel and clear-all cases, and acts only on `done_o`. Address 2 never changes `done_o`.
- R10: When a completion sets a bit in the same cycle that any software clear targets it, the bit ends up set.
- R11: Reads of address 2 or 3 return 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cmpl_vld_i | input | 1 | One-cycle transfer completion pulse |
| cmpl_ch_i | input | 6 | Channel that completed |
| cmpl_irq_en_i | input | 1 | Descriptor requests an interrupt on completion |
| bus_wr_i | input | 1 | Register write strobe |
| bus_rd_i | input | 1 | Register read strobe |
| bus_addr_i | input | 2 | Register word address |
| bus_wdata_i | input | 32 | Write data |
| bus_rdata_o | output | 32 | Registered read data, valid the cycle after a read |
| irq_o | output | 64 | Per-channel interrupt request lines |
| done_o | output | 64 | Per-channel DONE flags |

## Verification
A completion pulse and a software clear can reach the same flag in one cycle. The clear can come from a bitmap write, a single-channel command or a clear-all command. The bench forces these collisions on purpose, for example a completion on channel 7 together with a write-one-to-clear of bit 7, or a completion on channel 40 together with a clear-all. It also keeps up a long random mix where the two events often coincide. Each cycle the bench compares `irq_o`, `done_o` and `bus_rdata_o` with a behavioural 64-bit model in which the set is applied after the clear.

// File: rtl/dma_irq_pkg.sv
package dma_irq_pkg;

  localparam int CMD_W = 8;

  // encoded clear command byte: skip flag on top, selector below
  typedef struct packed {
    logic       skip;
    logic [6:0] sel;
  } clr_cmd_t;

endpackage

// File: rtl/dma_clr_decode.sv
module dma_clr_decode
  import dma_irq_pkg::*;
#(
  parameter int NUM_CH = 64
) (
  input  logic              en_i,
  input  clr_cmd_t          cmd_i,
  output logic [NUM_CH-1:0] mask_o
);

  logic hit_all;
  logic active;

  assign active  = en_i && !cmd_i.skip;
  assign hit_all = int'(cmd_i.sel) >= NUM_CH;

  for (genvar i = 0; i < NUM_CH; i++) begin : g_bit
    assign mask_o[i] = active && (hit_all || (cmd_i.sel == 7'(i)));
  end

endmodule

// File: rtl/dma_flag_bank.sv
module dma_flag_bank #(
  parameter int N = 64
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [N-1:0] set_i,
  input  logic [N-1:0] clr_i,
  output logic [N-1:0] q_o
);

  // set has priority so a completion is never lost to a clear
  for (genvar i = 0; i < N; i++) begin : g_flag
    always_ff @(posedge clk) begin
      if (rst)           q_o[i] <= 1'b0;
      else if (set_i[i]) q_o[i] <= 1'b1;
      else if (clr_i[i]) q_o[i] <= 1'b0;
    end
  end

endmodule

// File: rtl/dma_reg_port.sv
module dma_reg_port
  import dma_irq_pkg::*;
#(
  parameter int NUM_CH = 64,
  parameter int DW     = 32,
  localparam int NW    = NUM_CH / DW,
  localparam int AW    = $clog2(NW + 2)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_i,
  input  logic              rd_i,
  input  logic [AW-1:0]     addr_i,
  input  logic [DW-1:0]     wdata_i,
  input  logic [NUM_CH-1:0] pend_i,
  output logic [NUM_CH-1:0] w1c_o,
  output logic              irq_cmd_en_o,
  output logic              done_cmd_en_o,
  output clr_cmd_t          cmd_o,
  output logic [DW-1:0]     rdata_o
);

  localparam logic [AW-1:0] A_IRQ_CMD  = AW'(NW);
  localparam logic [AW-1:0] A_DONE_CMD = AW'(NW + 1);

  logic [DW-1:0] rd_mux;

  for (genvar w = 0; w < NW; w++) begin : g_word
    assign w1c_o[w*DW +: DW] = (wr_i && addr_i == AW'(w)) ? wdata_i : '0;
  end

  assign irq_cmd_en_o  = wr_i && addr_i == A_IRQ_CMD;
  assign done_cmd_en_o = wr_i && addr_i == A_DONE_CMD;
  assign cmd_o         = clr_cmd_t'(wdata_i[CMD_W-1:0]);

  // command registers read back as zero
  always_comb begin
    rd_mux = '0;
    for (int w = 0; w < NW; w++) begin
      if (addr_i == AW'(w)) rd_mux = pend_i[w*DW +: DW];
    end
  end

  always_ff @(posedge clk) begin
    if (rst)       rdata_o <= '0;
    else if (rd_i) rdata_o <= rd_mux;
    else           rdata_o <= '0;
  end

endmodule

// File: rtl/dma_irq_bank.sv
module dma_irq_bank
  import dma_irq_pkg::*;
#(
  parameter int NUM_CH  = 64,
  parameter int DW      = 32,
  localparam int NW     = NUM_CH / DW,
  localparam int AW     = $clog2(NW + 2),
  localparam int IDW    = $clog2(NUM_CH)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              cmpl_vld_i,
  input  logic [IDW-1:0]    cmpl_ch_i,
  input  logic              cmpl_irq_en_i,
  input  logic              bus_wr_i,
  input  logic              bus_rd_i,
  input  logic [AW-1:0]     bus_addr_i,
  input  logic [DW-1:0]     bus_wdata_i,
  output logic [DW-1:0]     bus_rdata_o,
  output logic [NUM_CH-1:0] irq_o,
  output logic [NUM_CH-1:0] done_o
);

  logic [NUM_CH-1:0] hit_ch;
  logic [NUM_CH-1:0] irq_set;
  logic [NUM_CH-1:0] w1c_mask;
  logic [NUM_CH-1:0] irq_cmd_mask;
  logic [NUM_CH-1:0] done_cmd_mask;
  logic              irq_cmd_en;
  logic              done_cmd_en;
  clr_cmd_t          cmd;

  for (genvar i = 0; i < NUM_CH; i++) begin : g_hit
    assign hit_ch[i] = cmpl_vld_i && (cmpl_ch_i == IDW'(i));
  end
  assign irq_set = cmpl_irq_en_i ? hit_ch : '0;

  dma_reg_port #(.NUM_CH(NUM_CH), .DW(DW)) port_i (
    .clk           (clk),
    .rst           (rst),
    .wr_i          (bus_wr_i),
    .rd_i          (bus_rd_i),
    .addr_i        (bus_addr_i),
    .wdata_i       (bus_wdata_i),
    .pend_i        (irq_o),
    .w1c_o         (w1c_mask),
    .irq_cmd_en_o  (irq_cmd_en),
    .done_cmd_en_o (done_cmd_en),
    .cmd_o         (cmd),
    .rdata_o       (bus_rdata_o)
  );

  dma_clr_decode #(.NUM_CH(NUM_CH)) irq_dec_i (
    .en_i   (irq_cmd_en),
    .cmd_i  (cmd),
    .mask_o (irq_cmd_mask)
  );

  dma_clr_decode #(.NUM_CH(NUM_CH)) done_dec_i (
    .en_i   (done_cmd_en),
    .cmd_i  (cmd),
    .mask_o (done_cmd_mask)
  );

  dma_flag_bank #(.N(NUM_CH)) irq_bank_i (
    .clk   (clk),
    .rst   (rst),
    .set_i (irq_set),
    .clr_i (w1c_mask | irq_cmd_mask),
    .q_o   (irq_o)
  );

  dma_flag_bank #(.N(NUM_CH)) done_bank_i (
    .clk   (clk),
    .rst   (rst),
    .set_i (hit_ch),
    .clr_i (done_cmd_mask),
    .q_o   (done_o)
  );

endmodule

// File: rtl/dma_irq_bank_chk.sv
module dma_irq_bank_chk #(
  parameter int NUM_CH = 64,
  parameter int DW     = 32,
  localparam int NW    = NUM_CH / DW,
  localparam int AW    = $clog2(NW + 2),
  localparam int IDW   = $clog2(NUM_CH)
) (
  input logic              clk,
  input logic              rst,
  input logic              cmpl_vld_i,
  input logic [IDW-1:0]    cmpl_ch_i,
  input logic              cmpl_irq_en_i,
  input logic              bus_wr_i,
  input logic              bus_rd_i,
  input logic [AW-1:0]     bus_addr_i,
  input logic [DW-1:0]     bus_wdata_i,
  input logic [DW-1:0]     bus_rdata_o,
  input logic [NUM_CH-1:0] irq_o,
  input logic [NUM_CH-1:0] done_o
);

  localparam logic [AW-1:0] A_IRQ_CMD  = AW'(NW);
  localparam logic [AW-1:0] A_DONE_CMD = AW'(NW + 1);

  // R1
  reset_clears_chk: assert property (@(posedge clk)
    rst |=> (irq_o == '0 && done_o == '0 && bus_rdata_o == '0));

  // R2
  irq_set_chk: assert property (@(posedge clk) disable iff (rst)
    (cmpl_vld_i && cmpl_irq_en_i) |=> irq_o[$past(cmpl_ch_i)]);

  // R2
  no_spurious_irq_chk: assert property (@(posedge clk) disable iff (rst)
    !(cmpl_vld_i && cmpl_irq_en_i) |=> ((irq_o & ~$past(irq_o)) == '0));

  // R3
  done_set_chk: assert property (@(posedge clk) disable iff (rst)
    cmpl_vld_i |=> done_o[$past(cmpl_ch_i)]);

  // R6
  cmd_skip_chk: assert property (@(posedge clk) disable iff (rst)
    (bus_wr_i && bus_addr_i == A_IRQ_CMD && bus_wdata_i[7] && !cmpl_vld_i)
      |=> $stable(irq_o));

  // R8
  clear_all_chk: assert property (@(posedge clk) disable iff (rst)
    (bus_wr_i && bus_addr_i == A_IRQ_CMD && !bus_wdata_i[7] &&
     int'(bus_wdata_i[6:0]) >= NUM_CH && !cmpl_vld_i) |=> (irq_o == '0));

  // R11
  cmd_read_zero_chk: assert property (@(posedge clk) disable iff (rst)
    (bus_rd_i && (bus_addr_i == A_IRQ_CMD || bus_addr_i == A_DONE_CMD))
      |=> (bus_rdata_o == '0));

  // R9
  done_untouched_chk: assert property (@(posedge clk) disable iff (rst)
    (!cmpl_vld_i && !(bus_wr_i && bus_addr_i == A_DONE_CMD)) |=> $stable(done_o));

endmodule

bind dma_irq_bank dma_irq_bank_chk #(.NUM_CH(NUM_CH), .DW(DW)) chk_i (
  .clk           (clk),
  .rst           (rst),
  .cmpl_vld_i    (cmpl_vld_i),
  .cmpl_ch_i     (cmpl_ch_i),
  .cmpl_irq_en_i (cmpl_irq_en_i),
  .bus_wr_i      (bus_wr_i),
  .bus_rd_i      (bus_rd_i),
  .bus_addr_i    (bus_addr_i),
  .bus_wdata_i   (bus_wdata_i),
  .bus_rdata_o   (bus_rdata_o),
  .irq_o         (irq_o),
  .done_o        (done_o)
);

// File: tb/dma_irq_bank_tb_top.sv
module dma_irq_bank_tb_top;

  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        cmpl_vld = 1'b0;
  logic [5:0]  cmpl_ch = '0;
  logic        cmpl_en = 1'b0;
  logic        wr = 1'b0;
  logic        rd = 1'b0;
  logic [1:0]  addr = '0;
  logic [31:0] wdata = '0;
  logic [31:0] rdata;
  logic [63:0] irq;
  logic [63:0] done;

  int n_checks = 0;
  int n_fail   = 0;
  bit cmp_on   = 1'b0;
  bit finished = 1'b0;

  // behavioural reference state
  logic [63:0] m_irq  = '0;
  logic [63:0] m_done = '0;
  logic [31:0] m_rd   = '0;

  always #(CLK_PERIOD/2) clk = ~clk;

  dma_irq_bank dut_i (
    .clk           (clk),
    .rst           (rst),
    .cmpl_vld_i    (cmpl_vld),
    .cmpl_ch_i     (cmpl_ch),
    .cmpl_irq_en_i (cmpl_en),
    .bus_wr_i      (wr),
    .bus_rd_i      (rd),
    .bus_addr_i    (addr),
    .bus_wdata_i   (wdata),
    .bus_rdata_o   (rdata),
    .irq_o         (irq),
    .done_o        (done)
  );

  function automatic logic [63:0] cmd_mask(input logic [7:0] b);
    if (b[7]) return '0;
    if (b[6:0] >= 7'd64) return '1;
    return 64'd1 << b[5:0];
  endfunction

  always @(posedge clk) begin
    logic [63:0] ci, cd;
    if (rst) begin
      m_irq = '0; m_done = '0; m_rd = '0;
    end else begin
      ci = '0; cd = '0;
      m_rd = '0;
      if (rd) begin
        if (addr == 2'd0) m_rd = m_irq[31:0];
        else if (addr == 2'd1) m_rd = m_irq[63:32];
      end
      if (wr) begin
        case (addr)
          2'd0: ci[31:0]  = wdata;
          2'd1: ci[63:32] = wdata;
          2'd2: ci = cmd_mask(wdata[7:0]);
          default: cd = cmd_mask(wdata[7:0]);
        endcase
      end
      m_irq  = m_irq & ~ci;
      m_done = m_done & ~cd;
      if (cmpl_vld) begin
        m_done[cmpl_ch] = 1'b1;
        if (cmpl_en) m_irq[cmpl_ch] = 1'b1;
      end
    end
  end

  task automatic chk64(input string tag, input logic [63:0] act, input logic [63:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // per-cycle comparison against the reference model
  always @(negedge clk) begin
    if (cmp_on && !finished) begin
      chk64("R2 R5 R7 R8 R10 irq vs model", irq, m_irq);
      chk64("R3 R9 done vs model", done, m_done);
      chk64("R4 R11 rdata vs model", {32'd0, rdata}, {32'd0, m_rd});
    end
  end

  // one bus/completion cycle, inputs driven after the falling edge
  task automatic step(input bit w, input bit r, input logic [1:0] a,
                      input logic [31:0] d, input bit cv, input int ch, input bit en);
    wr = w; rd = r; addr = a; wdata = d;
    cmpl_vld = cv; cmpl_ch = 6'(ch); cmpl_en = en;
    @(posedge clk);
    @(negedge clk);
    wr = 0; rd = 0; cmpl_vld = 0; cmpl_en = 0;
  endtask

  task automatic idle();
    step(0, 0, 2'd0, 32'd0, 0, 0, 0);
  endtask

  initial begin
    #(CLK_PERIOD * 200000);
    if (!finished) begin
      n_fail++;
      n_checks++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("  [TB] %0d tests run, %0d failed", n_checks, n_fail);
      $finish;
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    // R1: reset state
    chk64("R1 irq reset", irq, '0);
    chk64("R1 done reset", done, '0);
    chk64("R1 rdata reset", {32'd0, rdata}, '0);
    rst = 0;
    cmp_on = 1'b1;

    // R2 R4: channel 63 sits in bit 31 of the high word
    step(0, 0, 2'd0, 0, 1, 63, 1);
    chk64("R2 ch63 set", {63'd0, irq[63]}, 64'd1);
    step(0, 1, 2'd1, 0, 0, 0, 0);
    chk64("R4 high word", {32'd0, rdata}, {32'd0, 32'h8000_0000});

    // R2 R3: completion without interrupt enable
    step(0, 0, 2'd0, 0, 1, 5, 0);
    chk64("R2 no-enable irq", {63'd0, irq[5]}, 64'd0);
    chk64("R3 done set", {63'd0, done[5]}, 64'd1);

    // R4: channel 0 in bit 0 of the low word
    step(0, 0, 2'd0, 0, 1, 0, 1);
    step(0, 1, 2'd0, 0, 0, 0, 0);
    chk64("R4 low word", {32'd0, rdata}, 64'd1);

    // R5: zero bits untouched, one bits clear
    step(1, 0, 2'd1, 32'h7FFF_FFFF, 0, 0, 0);
    chk64("R5 zero bit keeps", {63'd0, irq[63]}, 64'd1);
    step(1, 0, 2'd1, 32'h8000_0000, 0, 0, 0);
    chk64("R5 one bit clears", {63'd0, irq[63]}, 64'd0);
    chk64("R5 done unaffected", {63'd0, done[63]}, 64'd1);

    // R6 R7: skip flag, then single-channel clear
    step(0, 0, 2'd0, 0, 1, 10, 1);
    step(0, 0, 2'd0, 0, 1, 20, 1);
    step(1, 0, 2'd2, 32'h0000_008A, 0, 0, 0);
    chk64("R6 skip keeps ch10", {63'd0, irq[10]}, 64'd1);
    step(1, 0, 2'd2, 32'h0000_000A, 0, 0, 0);
    chk64("R7 ch10 cleared", {63'd0, irq[10]}, 64'd0);
    chk64("R7 ch20 kept", {63'd0, irq[20]}, 64'd1);

    // R8: clear-all at both ends of the range
    step(0, 0, 2'd0, 0, 1, 33, 1);
    step(1, 0, 2'd2, 32'h0000_0040, 0, 0, 0);
    chk64("R8 clear-all 64", irq, '0);
    step(0, 0, 2'd0, 0, 1, 50, 1);
    step(1, 0, 2'd2, 32'h0000_007F, 0, 0, 0);
    chk64("R8 clear-all 127", irq, '0);

    // R9: done command path
    step(0, 0, 2'd0, 0, 1, 12, 1);
    step(1, 0, 2'd2, 32'h0000_0040, 0, 0, 0);
    chk64("R9 irq cmd leaves done", {63'd0, done[12]}, 64'd1);
    step(1, 0, 2'd3, 32'h0000_0085, 0, 0, 0);
    chk64("R9 done skip", {63'd0, done[5]}, 64'd1);
    step(0, 0, 2'd0, 0, 1, 12, 1);
    step(1, 0, 2'd3, 32'h0000_0005, 0, 0, 0);
    chk64("R9 done single", {63'd0, done[5]}, 64'd0);
    chk64("R9 irq untouched", {63'd0, irq[12]}, 64'd1);
    step(1, 0, 2'd3, 32'h0000_0041, 0, 0, 0);
    chk64("R9 done clear-all", done, '0);

    // R10: set beats a concurrent clear of the same bit
    step(1, 0, 2'd0, 32'h0000_0080, 1, 7, 1);
    chk64("R10 w1c vs set", {63'd0, irq[7]}, 64'd1);
    step(1, 0, 2'd2, 32'h0000_0040, 1, 40, 1);
    chk64("R10 clear-all vs set", irq, 64'd1 << 40);
    step(1, 0, 2'd2, 32'h0000_0028, 1, 40, 1);
    chk64("R10 single vs set", {63'd0, irq[40]}, 64'd1);

    // R11: command registers read as zero
    step(0, 1, 2'd2, 0, 0, 0, 0);
    chk64("R11 read irq cmd", {32'd0, rdata}, '0);
    step(0, 1, 2'd3, 0, 0, 0, 0);
    chk64("R11 read done cmd", {32'd0, rdata}, '0);
    idle();
    chk64("R4 idle rdata zero", {32'd0, rdata}, '0);

    // mixed random traffic, judged by the per-cycle model comparison
    for (int i = 0; i < 4000; i++) begin
      automatic int  sel = $urandom % 8;
      automatic logic [31:0] d = $urandom;
      automatic int  ch = $urandom % 64;
      if (sel >= 2 && ($urandom % 2)) d = {24'd0, 1'b0, (($urandom % 4) == 0) ? 7'd64 : 7'(ch)};
      if (($urandom % 8) == 0) d[7] = 1'b1;
      step(($urandom % 3) != 0, ($urandom % 2) == 1, 2'($urandom % 4), d,
           ($urandom % 3) != 0, ch, ($urandom % 4) != 0);
    end

    finished = 1'b1;
    $display("  [TB] %0d tests run, %0d failed", n_checks, n_fail);
    $finish;
  end

endmodule